// File: doc/BRIEF.md
# Per-Channel DMA Result Queue and Interrupt Controller

This block is the software-facing completion side of a multi-channel DMA engine. For every channel it holds a short queue of command pointers that software writes and the engine drains, a small queue of result words that the engine fills when a command finishes, flushes or fails, a configuration word, and a six-deep history of engine diagnostic words captured on abnormal completions. All channels share one interrupt status register with a bit per channel, and a single `irq` line is high while any of its bits is set.

Software reaches everything through a simple register port: a write strobe, a read strobe, a byte address and 32-bit data. Reading a channel's result register removes the oldest result from that channel's queue. On the engine side, commands leave and completion events arrive over per-channel valid/ready handshakes. A transfer happens only in a cycle where both valid and ready are high, and the side holding valid must keep its data steady until then. The block holds `evt_ready` low while a channel's result queue is full, and in a cycle where software's command write to that channel is being refused.

Top module: `chan_result_hub`

## Requirements
- R1: After reset every channel's status word reads 0x00000001, every config word reads 0, the interrupt status reads 0, `irq` is low, every `evt_ready` bit is high and every `cmd_valid` bit is low.
- R2: A write to a channel's command register enters that channel's command queue (2 entries). `cmd_valid` is high while the queue is not empty, and `cmd_ptr` shows the oldest entry, which leaves the queue in a cycle where `cmd_valid` and `cmd_ready` are both high. Status bits 28:27 hold the queue count, and status bit 0 (ready) is 1 only while that count is below 2.
- R3: A command write while status bit 0 is 0 does not enter the queue, and it pushes the error result 0x80000008 into that channel's result queue.
- R4: An accepted event with code bits {error, flush, done, user} pushes the result {1, 27 zeros, code} into the channel's result queue. Bit 31 is valid, bit 3 error, bit 2 flush, bit 1 done and bit 0 user. The done bit survives only when config bit 2 is 1 and the flush bit only when config bit 1 is 1. If no code bit survives, nothing is pushed. A successful completion therefore reads 0x80000002.
- R5: Results come out in arrival order. A read of the result register returns the oldest result and removes it, and a read of an empty queue returns 0. Status bits 31:29 hold the result count, and status bit 1 is 1 exactly while that count is non-zero.
- R6: `evt_ready` for a channel is low while its result queue holds 4 entries, and during a cycle in which a command write to that channel is being refused. It is high otherwise.
- R7: A push into a channel's result queue sets that channel's interrupt status bit only when config bit 0 of that channel is 1. `irq` is high while any interrupt status bit is set.
- R8: A read of the interrupt status register returns one bit per channel (bit n is channel n) and clears them. Pushes on several channels in one cycle all set their bits. A bit set in the same cycle as the read survives for the next read.
- R9: An accepted event whose raw code has error or flush set shifts that channel's `evt_info` word into diagnostic slot 0, and each older slot moves up one place (slots 0 to 5). This happens even when the flush bit is masked out by config. Other events leave the slots unchanged.
- R10: The register port uses byte addresses, with the channel in addr[5:2] and the bank in addr[9:6]. The banks are: 0 command (write), 1 result (read pops), 2 to 7 diagnostic slots 0 to 5, 8 status, 9 config (bits 2:0 read/write), and 10 interrupt status. Read data appears on `reg_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| evt_valid | input | 16 | Per-channel completion event valid |
| evt_code | input | 64 | Per-channel 4-bit event code {error, flush, done, user} |
| evt_info | input | 512 | Per-channel 32-bit diagnostic word sent with the event |
| evt_ready | output | 16 | Per-channel event ready |
| cmd_valid | output | 16 | Per-channel command available to the engine |
| cmd_ptr | output | 512 | Per-channel oldest command pointer |
| cmd_ready | input | 16 | Per-channel engine takes the command |
| irq | output | 1 | High while any interrupt status bit is set |

## Verification
Every state change lands on the clock edge that samples the stimulus. Queue counts, status words, interrupt bits, diagnostic slots and `cmd_ptr` all show the new value right after that edge. Read data comes back one edge after the read strobe, and `evt_ready` follows a refused command write in the same cycle, before any edge. The bench drives all inputs on falling edges and holds them across exactly one rising edge. It samples registered results at the next falling edge, and it samples `evt_ready` a short delay after driving the refused write, while that write is still applied.

// File: rtl/chan_hub_pkg.sv
package chan_hub_pkg;
  localparam int WORD_W = 32;

  // register banks (addr[9:6])
  localparam logic [3:0] BK_CMD  = 4'd0;
  localparam logic [3:0] BK_RES  = 4'd1;
  localparam logic [3:0] BK_DIAG = 4'd2;
  localparam logic [3:0] BK_STAT = 4'd8;
  localparam logic [3:0] BK_CFG  = 4'd9;
  localparam logic [3:0] BK_IRQ  = 4'd10;

  // config bits
  localparam int CFG_IEN   = 0;
  localparam int CFG_KFLSH = 1;
  localparam int CFG_KTOP  = 2;

  // event code bits
  localparam int EV_USER = 0;
  localparam int EV_DONE = 1;
  localparam int EV_FLSH = 2;
  localparam int EV_ERR  = 3;

  localparam logic [WORD_W-1:0] RES_REFUSED = 32'h8000_0008;

  function automatic logic [WORD_W-1:0] pack_result(input logic [3:0] code);
    return {1'b1, 27'd0, code};
  endfunction
endpackage

// File: rtl/hub_fifo.sv
module hub_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/hub_channel.sv
module hub_channel
  import chan_hub_pkg::*;
#(
  parameter int CMD_DEPTH = 2,
  parameter int RES_DEPTH = 4,
  parameter int NUM_DIAG  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic [2:0]                       cfg_din,
  input  logic                             cmd_wr,
  input  logic [WORD_W-1:0]                cmd_din,
  input  logic                             res_rd,
  input  logic                             evt_valid,
  input  logic [3:0]                       evt_code,
  input  logic [WORD_W-1:0]                evt_info,
  output logic                             evt_ready,
  output logic                             cmd_valid,
  output logic [WORD_W-1:0]                cmd_ptr,
  input  logic                             cmd_ready,
  output logic [WORD_W-1:0]                res_head,
  output logic [WORD_W-1:0]                status,
  output logic [2:0]                       cfg,
  output logic [NUM_DIAG-1:0][WORD_W-1:0]  diag,
  output logic                             irq_set
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int RCW = $clog2(RES_DEPTH + 1);

  logic [CCW-1:0]    cmd_cnt;
  logic              cmd_full, cmd_empty;
  logic [RCW-1:0]    res_cnt;
  logic              res_full, res_empty;
  logic [WORD_W-1:0] res_q_head;
  logic              refused, evt_fire, res_push, diag_shift;
  logic [3:0]        kept;
  logic [WORD_W-1:0] res_word;

  // R3: a write to a full command queue is refused
  assign refused   = cmd_wr & cmd_full;
  // R6: back-pressure on the event handshake
  assign evt_ready = ~res_full & ~refused;
  assign evt_fire  = evt_valid & evt_ready;

  // R4: config-gated code bits
  always_comb begin
    kept          = evt_code;
    kept[EV_DONE] = evt_code[EV_DONE] & cfg[CFG_KTOP];
    kept[EV_FLSH] = evt_code[EV_FLSH] & cfg[CFG_KFLSH];
  end

  assign res_push   = (evt_fire & (kept != 4'd0)) | (refused & ~res_full);
  assign res_word   = refused ? RES_REFUSED : pack_result(kept);
  // R7
  assign irq_set    = res_push & cfg[CFG_IEN];
  // R9
  assign diag_shift = evt_fire & (evt_code[EV_ERR] | evt_code[EV_FLSH]);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= cfg_din;
  end

  hub_fifo #(.W(WORD_W), .DEPTH(CMD_DEPTH), .CW(CCW)) u_cmdq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_wr),
    .din   (cmd_din),
    .pop   (cmd_ready),
    .head  (cmd_ptr),
    .count (cmd_cnt),
    .full  (cmd_full),
    .empty (cmd_empty)
  );
  assign cmd_valid = ~cmd_empty;

  hub_fifo #(.W(WORD_W), .DEPTH(RES_DEPTH), .CW(RCW)) u_resq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (res_push),
    .din   (res_word),
    .pop   (res_rd),
    .head  (res_q_head),
    .count (res_cnt),
    .full  (res_full),
    .empty (res_empty)
  );
  // R5: empty queue reads as zero
  assign res_head = res_empty ? '0 : res_q_head;

  // R2 R5: status word layout
  assign status = {3'(res_cnt), 2'(cmd_cnt), 25'd0, ~res_empty, ~cmd_full};

  for (genvar k = 0; k < NUM_DIAG; k++) begin : g_diag
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n)          diag[k] <= '0;
        else if (diag_shift) diag[k] <= evt_info;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n)          diag[k] <= '0;
        else if (diag_shift) diag[k] <= diag[k-1];
      end
    end
  end
endmodule

// File: rtl/hub_irq.sv
module hub_irq #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set,
  input  logic              clr,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);
  // R8: clear on read, but a same-cycle set survives
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (clr ? '0 : pend) | set;
  end
  assign irq = |pend;
endmodule

// File: rtl/chan_result_hub.sv
module chan_result_hub
  import chan_hub_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int CMD_DEPTH = 2,
  parameter int RES_DEPTH = 4,
  parameter int NUM_DIAG  = 6,
  parameter int ADDR_W    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_CH-1:0]        evt_valid,
  input  logic [NUM_CH*4-1:0]      evt_code,
  input  logic [NUM_CH*32-1:0]     evt_info,
  output logic [NUM_CH-1:0]        evt_ready,
  output logic [NUM_CH-1:0]        cmd_valid,
  output logic [NUM_CH*32-1:0]     cmd_ptr,
  input  logic [NUM_CH-1:0]        cmd_ready,
  output logic                     irq
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [3:0]                                  bank;
  logic [CH_W-1:0]                             ch;
  logic [NUM_CH-1:0][WORD_W-1:0]               stat_w;
  logic [NUM_CH-1:0][WORD_W-1:0]               head_w;
  logic [NUM_CH-1:0][2:0]                      cfg_w;
  logic [NUM_CH-1:0][NUM_DIAG-1:0][WORD_W-1:0] diag_w;
  logic [NUM_CH-1:0]                           irq_set;
  logic [NUM_CH-1:0]                           pend;
  logic                                        irq_rd;
  logic [WORD_W-1:0]                           rd_word;

  // R10: address decode
  assign ch     = reg_addr[CH_W+1:2];
  assign bank   = reg_addr[CH_W+5:CH_W+2];
  assign irq_rd = reg_rd & (bank == BK_IRQ);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (ch == CH_W'(i));

    hub_channel #(
      .CMD_DEPTH (CMD_DEPTH),
      .RES_DEPTH (RES_DEPTH),
      .NUM_DIAG  (NUM_DIAG)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (reg_wr & sel & (bank == BK_CFG)),
      .cfg_din   (reg_wdata[2:0]),
      .cmd_wr    (reg_wr & sel & (bank == BK_CMD)),
      .cmd_din   (reg_wdata),
      .res_rd    (reg_rd & sel & (bank == BK_RES)),
      .evt_valid (evt_valid[i]),
      .evt_code  (evt_code[i*4 +: 4]),
      .evt_info  (evt_info[i*32 +: 32]),
      .evt_ready (evt_ready[i]),
      .cmd_valid (cmd_valid[i]),
      .cmd_ptr   (cmd_ptr[i*32 +: 32]),
      .cmd_ready (cmd_ready[i]),
      .res_head  (head_w[i]),
      .status    (stat_w[i]),
      .cfg       (cfg_w[i]),
      .diag      (diag_w[i]),
      .irq_set   (irq_set[i])
    );
  end

  hub_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clr   (irq_rd),
    .pend  (pend),
    .irq   (irq)
  );

  always_comb begin
    rd_word = '0;
    if (bank == BK_RES)       rd_word = head_w[ch];
    else if (bank == BK_STAT) rd_word = stat_w[ch];
    else if (bank == BK_CFG)  rd_word = {29'd0, cfg_w[ch]};
    else if (bank == BK_IRQ)  rd_word = 32'(pend);
    else begin
      for (int k = 0; k < NUM_DIAG; k++) begin
        if (bank == 4'(int'(BK_DIAG) + k)) rd_word = diag_w[ch][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/chan_result_hub_chk.sv
module chan_result_hub_chk #(
  parameter int NUM_CH    = 16,
  parameter int CMD_DEPTH = 2,
  parameter int RES_DEPTH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    irq_rd,
  input logic                    irq,
  input logic [NUM_CH-1:0]       irq_set,
  input logic [NUM_CH-1:0]       evt_ready,
  input logic [NUM_CH-1:0]       cmd_valid,
  input logic [NUM_CH-1:0][31:0] stat_w
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    // R5
    res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(stat_w[i][31:29]) <= RES_DEPTH);
    // R6
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(stat_w[i][31:29]) == RES_DEPTH) |-> !evt_ready[i]);
    // R2
    cmd_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid[i] == (stat_w[i][28:27] != 2'd0));
    // R5
    res_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_w[i][1] == (stat_w[i][31:29] != 3'd0));
  end

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|irq_set));
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && irq_set == '0) |=> !irq);
endmodule

bind chan_result_hub chan_result_hub_chk #(
  .NUM_CH    (NUM_CH),
  .CMD_DEPTH (CMD_DEPTH),
  .RES_DEPTH (RES_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_rd    (irq_rd),
  .irq       (irq),
  .irq_set   (irq_set),
  .evt_ready (evt_ready),
  .cmd_valid (cmd_valid),
  .stat_w    (stat_w)
);

// File: tb/chan_result_hub_test.sv
module chan_result_hub_test;
  localparam int NC = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]    reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [NC-1:0]  evt_valid = '0;
  logic [NC*4-1:0]  evt_code = '0;
  logic [NC*32-1:0] evt_info = '0;
  logic [NC-1:0]  evt_ready;
  logic [NC-1:0]  cmd_valid;
  logic [NC*32-1:0] cmd_ptr;
  logic [NC-1:0]  cmd_ready = '0;
  logic           irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chan_result_hub uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_info(evt_info),
    .evt_ready(evt_ready), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr),
    .cmd_ready(cmd_ready), .irq(irq)
  );

  function automatic logic [11:0] ad(input int bank, input int ch);
    return 12'((bank << 6) | (ch << 2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int ch, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad(bank, ch); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int bank, input int ch, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ad(bank, ch);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ev(input int ch, input logic [3:0] code, input logic [31:0] info);
    @(negedge clk);
    evt_valid[ch] = 1'b1; evt_code[ch*4 +: 4] = code; evt_info[ch*32 +: 32] = info;
    @(negedge clk);
    evt_valid[ch] = 1'b0;
  endtask

  task automatic take(input int ch);
    @(negedge clk);
    cmd_ready[ch] = 1'b1;
    @(negedge clk);
    cmd_ready[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 evt_ready", 32'(evt_ready), 32'hFFFF);
    chk("R1 cmd_valid", 32'(cmd_valid), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(8, 0, d);  chk("R1 status ch0", d, 32'h0000_0001);
    rd(8, 15, d); chk("R1 status ch15", d, 32'h0000_0001);
    rd(9, 7, d);  chk("R1 config ch7", d, 32'h0);
    rd(10, 0, d); chk("R1 irq status", d, 32'h0);
  endtask

  task automatic t_cmd_queue();
    logic [31:0] d;
    wr(0, 3, 32'h0000_1000);
    wr(0, 3, 32'h0000_2000);
    rd(8, 3, d); chk("R2 status full queue", d, 32'h1000_0000);
    chk("R2 cmd_valid", 32'(cmd_valid[3]), 32'h1);
    chk("R2 oldest ptr", cmd_ptr[3*32 +: 32], 32'h0000_1000);
    take(3);
    chk("R2 next ptr", cmd_ptr[3*32 +: 32], 32'h0000_2000);
    rd(8, 3, d); chk("R2 status one left", d, 32'h0800_0001);
  endtask

  task automatic t_reject();
    logic [31:0] d;
    wr(0, 3, 32'h0000_3000);
    wr(0, 3, 32'h0000_4000);
    rd(8, 3, d); chk("R3 status after refused write", d, 32'h3000_0002);
    rd(1, 3, d); chk("R3 refused result", d, 32'h8000_0008);
    take(3);
    chk("R3 queue order", cmd_ptr[3*32 +: 32], 32'h0000_3000);
    take(3);
    chk("R3 refused ptr not queued", 32'(cmd_valid[3]), 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    wr(9, 5, 32'h6);
    rd(9, 5, d); chk("R10 config readback", d, 32'h6);
    ev(5, 4'b0010, 32'h0);
    ev(5, 4'b1111, 32'h0);
    wr(9, 5, 32'h0);
    ev(5, 4'b0010, 32'h0);
    ev(5, 4'b0100, 32'h0);
    ev(5, 4'b0001, 32'h0);
    rd(8, 5, d); chk("R4 masked events dropped", d, 32'h6000_0003);
    rd(1, 5, d); chk("R4 success word", d, 32'h8000_0002);
    rd(1, 5, d); chk("R4 all bits word", d, 32'h8000_000F);
    rd(1, 5, d); chk("R4 user word", d, 32'h8000_0001);
    rd(1, 5, d); chk("R5 empty read", d, 32'h0);
    rd(8, 5, d); chk("R5 drained status", d, 32'h0000_0001);
  endtask

  task automatic t_backpressure();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) ev(6, 4'b1000, 32'h0);
    chk("R6 full stalls", 32'(evt_ready[6]), 32'h0);
    rd(8, 6, d); chk("R5 full count", d, 32'h8000_0003);
    rd(1, 6, d); chk("R5 pop word", d, 32'h8000_0008);
    chk("R6 room again", 32'(evt_ready[6]), 32'h1);
    wr(0, 6, 32'h10);
    wr(0, 6, 32'h20);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad(0, 6); reg_wdata = 32'h30;
    #1;
    chk("R6 refused write stalls", 32'(evt_ready[6]), 32'h0);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(9, 1, 32'h7);
    wr(9, 2, 32'h7);
    wr(9, 4, 32'h6);
    @(negedge clk);
    evt_valid = 16'h0016;
    evt_code[1*4 +: 4] = 4'b0010;
    evt_code[2*4 +: 4] = 4'b0010;
    evt_code[4*4 +: 4] = 4'b0010;
    @(negedge clk);
    evt_valid = '0;
    chk("R7 irq raised", 32'(irq), 32'h1);
    rd(10, 0, d); chk("R8 simultaneous bits, R7 ch4 disabled", d, 32'h0000_0006);
    chk("R8 cleared by read", 32'(irq), 32'h0);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ad(10, 0);
    evt_valid[1] = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; evt_valid[1] = 1'b0;
    chk("R8 read during push", reg_rdata, 32'h0);
    chk("R8 push survives", 32'(irq), 32'h1);
    rd(10, 0, d); chk("R8 late bit", d, 32'h0000_0002);
  endtask

  task automatic t_diag();
    logic [31:0] d;
    ev(9, 4'b1000, 32'hAAAA_0001);
    ev(9, 4'b0100, 32'hBBBB_0002);
    ev(9, 4'b0010, 32'hCCCC_0003);
    rd(2, 9, d); chk("R9 slot0", d, 32'hBBBB_0002);
    rd(3, 9, d); chk("R9 slot1", d, 32'hAAAA_0001);
    rd(7, 9, d); chk("R9 slot5", d, 32'h0);
    rd(8, 9, d); chk("R9 status ch9", d, 32'h2000_0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_queue();
    t_reject();
    t_events();
    t_backpressure();
    t_irq();
    t_diag();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule